// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block is the host-side engine that talks to a service processor through a pair of mailbox register banks. Requests (a 16-bit command made of an 8-bit class and an 8-bit opcode, 16 control flags and three 64-bit payload words) enter a small queue. The engine serves one request at a time. It stamps a sequence number on the request, writes the four command words into the mailbox and rings the engine-side doorbell. It then waits for the response doorbell or for a timeout.

When a response arrives, the engine latches the four response words and clears the doorbell through its AND view. It compares the echoed header with what it sent and publishes a completion code with the primary and secondary status. A message whose class lies outside the legal range is refused before anything is written. A message that asks for no response completes as soon as the doorbell has been rung. After a timeout the message is abandoned, and a response that turns up later is wiped without disturbing the reported status.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, msg_state is 0 (unused), st_code is 0 (none), req_ready is 1 and no mailbox write is issued.
- R2: A request whose class (cmd[15:8]) lies outside 0xD1..0xD7 produces no mailbox write. It sets st_code 5 (rejected) and msg_state 6 (error), and it consumes no sequence number.
- R3: An accepted request writes mailbox addresses 0, 1, 2, 3 in consecutive cycles, followed in the next cycle by a write of 64'h1 to address 4 (engine doorbell). Word 0 is {16'h0, flags, seq[15:0], cmd[15:0]}. Words 1..3 are the payload words in order.
- R4: The first command after reset carries sequence 0. Each command sent increments the sequence modulo 2^SEQ_W, and st_seq reports the sequence of the completed message.
- R5: When flag bit 8 (value 0x0100) is clear, the message completes right after the doorbell ring with st_code 1 and msg_state 4 (done), without waiting for a response. Other flag bits, including 0x0200, do not change this.
- R6: Let R be the cycle of the doorbell ring write. If rsp_db is high in any cycle from R+2 to R+1+TMO_CYCLES, the response is accepted. Otherwise the message ends with st_code 3 and msg_state 5 (timeout).
- R7: On acceptance, the engine writes ~64'h1 to address 5 (doorbell AND view) in the next cycle, and rsp_d1..rsp_d3 hold the captured response words 1..3.
- R8: The response word 0 carries the primary status in bits [63:48] and the secondary status in bits [47:32], and these appear on st_pri and st_sec. With a matching header, st_code is 1 when the primary status is 0 and 2 otherwise, and msg_state is 4.
- R9: If bits [31:0] of response word 0 differ from the header that was sent (sequence, class, opcode), st_code is 4 and msg_state is 6.
- R10: A response doorbell that rises while the engine is idle is cleared through address 5 and leaves st_code and msg_state unchanged.
- R11: The completion status holds until the next request is taken from the queue, at which point st_code returns to 0.
- R12: Requests are served in arrival order. req_ready is 0 while the queue holds QDEPTH requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered to the queue |
| req_ready | output | 1 | Queue has room |
| req_cmd | input | 16 | Class (15:8) and opcode (7:0) |
| req_flags | input | 16 | Control flags; bit 8 asks for a response |
| req_w1 | input | 64 | Payload word 1 |
| req_w2 | input | 64 | Payload word 2 |
| req_w3 | input | 64 | Payload word 3 |
| mb_wr | output | 1 | Mailbox write strobe |
| mb_addr | output | 3 | 0..3 command words, 4 doorbell ring, 5 response doorbell AND view |
| mb_wdata | output | 64 | Mailbox write data |
| rsp_db | input | 1 | Response-waiting doorbell bit |
| rsp_w0 | input | 64 | Response word 0 (status and echoed header) |
| rsp_w1 | input | 64 | Response word 1 |
| rsp_w2 | input | 64 | Response word 2 |
| rsp_w3 | input | 64 | Response word 3 |
| msg_state | output | 3 | Current message state |
| st_code | output | 3 | Completion code |
| st_pri | output | 16 | Primary status of the last response |
| st_sec | output | 16 | Secondary status of the last response |
| st_seq | output | 16 | Sequence number of the completed message |
| rsp_d1 | output | 64 | Captured response word 1 |
| rsp_d2 | output | 64 | Captured response word 2 |
| rsp_d3 | output | 64 | Captured response word 3 |

## Verification
The hardest situation to reach from the ports is the edge of the timeout window. The last accepted response and the first late one differ by a single cycle, and the late one then lands while the engine is idle. The bench models the responder so that it raises the doorbell a programmed number of cycles after each ring. It sweeps that delay across every value from 1 to one past the window, which sets off both the last-cycle acceptance and the idle-time clear of a stale doorbell. A short sequence width lets the sweep run through a sequence wrap.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

  typedef enum logic [2:0] {
    MS_UNUSED  = 3'd0,
    MS_QUEUED  = 3'd1,
    MS_SENT    = 3'd2,
    MS_WRESP   = 3'd3,
    MS_DONE    = 3'd4,
    MS_TIMEOUT = 3'd5,
    MS_ERROR   = 3'd6
  } msg_state_e;

  typedef enum logic [2:0] {
    ST_NONE   = 3'd0,
    ST_OK     = 3'd1,
    ST_FAIL   = 3'd2,
    ST_TMO    = 3'd3,
    ST_SEQERR = 3'd4,
    ST_REJECT = 3'd5
  } st_code_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WR   = 3'd1,
    S_RING = 3'd2,
    S_POST = 3'd3,
    S_WAIT = 3'd4,
    S_CLR  = 3'd5
  } fsm_e;

  typedef struct packed {
    logic [15:0] cmd;
    logic [15:0] flags;
    logic [63:0] w1;
    logic [63:0] w2;
    logic [63:0] w3;
  } mbox_req_t;

  localparam logic [7:0]  CLASS_LO      = 8'hD1;
  localparam logic [7:0]  CLASS_HI      = 8'hD7;
  localparam int          FLAG_RESP_BIT = 8;
  localparam logic [2:0]  ADDR_RING     = 3'd4;
  localparam logic [2:0]  ADDR_CLEAR    = 3'd5;
  localparam logic [63:0] RING_VAL      = 64'h1;
  localparam logic [63:0] CLEAR_MASK    = ~64'h1;

  function automatic logic class_ok(input logic [7:0] cls);
    return (cls >= CLASS_LO) && (cls <= CLASS_HI);
  endfunction

  function automatic logic [63:0] pack_hdr(input logic [15:0] flags,
                                           input logic [15:0] seq,
                                           input logic [15:0] cmd);
    return {16'h0000, flags, seq, cmd};
  endfunction

endpackage

// File: rtl/mbox_req_fifo.sv
module mbox_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, rd_ptr_nx, wr_ptr, wr_ptr_nx;
  logic [CW-1:0] cnt, cnt_nx;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_ptr_nx = rd_ptr;
    wr_ptr_nx = wr_ptr;
    cnt_nx    = cnt;
    if (push) wr_ptr_nx = ptr_inc(wr_ptr);
    if (pop)  rd_ptr_nx = ptr_inc(rd_ptr);
    if (push && !pop)      cnt_nx = cnt + 1'b1;
    else if (pop && !push) cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_ptr_nx;
      wr_ptr <= wr_ptr_nx;
      cnt    <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout  = mem[rd_ptr];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  // R12: occupancy never passes the queue depth
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R12: an empty queue is never popped
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/mbox_tmo_cnt.sv
module mbox_tmo_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt, cnt_nx;

  assign hit = (cnt == CW'(LIMIT - 1));

  always_comb begin
    cnt_nx = cnt;
    if (clr)             cnt_nx = '0;
    else if (en && !hit) cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  // R6: the wait counter stays inside the programmed window
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/mbox_rsp_decode.sv
module mbox_rsp_decode
  import mbox_seq_pkg::*;
(
  input  logic [63:0] rsp_word0,
  input  logic [31:0] sent_hdr,
  output logic [15:0] pri,
  output logic [15:0] sec,
  output logic [2:0]  code
);
  always_comb begin
    pri = rsp_word0[63:48];
    sec = rsp_word0[47:32];
    if (rsp_word0[31:0] != sent_hdr) code = ST_SEQERR;
    else if (pri == 16'h0000)        code = ST_OK;
    else                             code = ST_FAIL;
  end
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_seq_pkg::*;
#(
  parameter int QDEPTH     = 4,
  parameter int TMO_CYCLES = 1000000,
  parameter int SEQ_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_cmd,
  input  logic [15:0] req_flags,
  input  logic [63:0] req_w1,
  input  logic [63:0] req_w2,
  input  logic [63:0] req_w3,
  output logic        mb_wr,
  output logic [2:0]  mb_addr,
  output logic [63:0] mb_wdata,
  input  logic        rsp_db,
  input  logic [63:0] rsp_w0,
  input  logic [63:0] rsp_w1,
  input  logic [63:0] rsp_w2,
  input  logic [63:0] rsp_w3,
  output logic [2:0]  msg_state,
  output logic [2:0]  st_code,
  output logic [15:0] st_pri,
  output logic [15:0] st_sec,
  output logic [15:0] st_seq,
  output logic [63:0] rsp_d1,
  output logic [63:0] rsp_d2,
  output logic [63:0] rsp_d3
);
  localparam int REQ_W = $bits(mbox_req_t);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // request queue
  logic       q_push, q_pop, q_full, q_empty;
  logic [REQ_W-1:0] q_dout;
  mbox_req_t  head, req_in;
  logic       head_ok;
  fsm_e       state_q, state_nx;

  assign req_in    = '{cmd: req_cmd, flags: req_flags, w1: req_w1, w2: req_w2, w3: req_w3};
  assign req_ready = !q_full;
  assign q_push    = req_valid && !q_full;
  assign q_pop     = (state_q == S_IDLE) && !q_empty;
  assign head      = mbox_req_t'(q_dout);
  assign head_ok   = class_ok(head.cmd[15:8]);

  mbox_req_fifo #(.W(REQ_W), .DEPTH(QDEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_i_n),
    .push  (q_push),
    .pop   (q_pop),
    .din   (req_in),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );

  // timeout window
  logic tmo_hit;
  mbox_tmo_cnt #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (state_q == S_POST),
    .en    (state_q == S_WAIT),
    .hit   (tmo_hit)
  );

  // message registers
  logic [1:0]       wr_idx_q, wr_idx_nx;
  mbox_req_t        hold_q, hold_nx;
  logic [15:0]      hseq_q, hseq_nx;
  logic [SEQ_W-1:0] seq_q, seq_nx;
  msg_state_e       ms_q, ms_nx;
  st_code_e         stc_q, stc_nx;
  logic [15:0]      pri_q, pri_nx, sec_q, sec_nx, sseq_q, sseq_nx;
  logic [63:0]      cap0_q, cap0_nx, cap1_q, cap1_nx, cap2_q, cap2_nx, cap3_q, cap3_nx;

  // response decode of the captured word 0
  logic [15:0] dec_pri, dec_sec;
  logic [2:0]  dec_code;
  mbox_rsp_decode u_dec (
    .rsp_word0 (cap0_q),
    .sent_hdr  ({hseq_q, hold_q.cmd}),
    .pri       (dec_pri),
    .sec       (dec_sec),
    .code      (dec_code)
  );

  always_comb begin
    state_nx  = state_q;
    wr_idx_nx = wr_idx_q;
    hold_nx   = hold_q;
    hseq_nx   = hseq_q;
    seq_nx    = seq_q;
    ms_nx     = ms_q;
    stc_nx    = stc_q;
    pri_nx    = pri_q;
    sec_nx    = sec_q;
    sseq_nx   = sseq_q;
    cap0_nx   = cap0_q;
    cap1_nx   = cap1_q;
    cap2_nx   = cap2_q;
    cap3_nx   = cap3_q;
    unique case (state_q)
      S_IDLE: begin
        if (q_pop) begin
          hold_nx = head;
          pri_nx  = '0;
          sec_nx  = '0;
          sseq_nx = '0;
          if (!head_ok) begin
            ms_nx  = MS_ERROR;
            stc_nx = ST_REJECT;
          end else begin
            hseq_nx   = 16'(seq_q);
            seq_nx    = seq_q + 1'b1;
            ms_nx     = MS_QUEUED;
            stc_nx    = ST_NONE;
            wr_idx_nx = '0;
            state_nx  = S_WR;
          end
        end
      end
      S_WR: begin
        wr_idx_nx = wr_idx_q + 1'b1;
        if (wr_idx_q == 2'd3) state_nx = S_RING;
      end
      S_RING: begin
        ms_nx    = MS_SENT;
        state_nx = S_POST;
      end
      S_POST: begin
        if (hold_q.flags[FLAG_RESP_BIT]) begin
          ms_nx    = MS_WRESP;
          state_nx = S_WAIT;
        end else begin
          ms_nx    = MS_DONE;
          stc_nx   = ST_OK;
          sseq_nx  = hseq_q;
          state_nx = S_IDLE;
        end
      end
      S_WAIT: begin
        if (rsp_db) begin
          cap0_nx  = rsp_w0;
          cap1_nx  = rsp_w1;
          cap2_nx  = rsp_w2;
          cap3_nx  = rsp_w3;
          state_nx = S_CLR;
        end else if (tmo_hit) begin
          ms_nx    = MS_TIMEOUT;
          stc_nx   = ST_TMO;
          sseq_nx  = hseq_q;
          state_nx = S_IDLE;
        end
      end
      S_CLR: begin
        stc_nx   = st_code_e'(dec_code);
        pri_nx   = dec_pri;
        sec_nx   = dec_sec;
        sseq_nx  = hseq_q;
        ms_nx    = (dec_code == ST_SEQERR) ? MS_ERROR : MS_DONE;
        state_nx = S_IDLE;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q  <= S_IDLE;
      wr_idx_q <= '0;
      hold_q   <= '0;
      hseq_q   <= '0;
      seq_q    <= '0;
      ms_q     <= MS_UNUSED;
      stc_q    <= ST_NONE;
      pri_q    <= '0;
      sec_q    <= '0;
      sseq_q   <= '0;
      cap0_q   <= '0;
      cap1_q   <= '0;
      cap2_q   <= '0;
      cap3_q   <= '0;
    end else begin
      state_q  <= state_nx;
      wr_idx_q <= wr_idx_nx;
      hold_q   <= hold_nx;
      hseq_q   <= hseq_nx;
      seq_q    <= seq_nx;
      ms_q     <= ms_nx;
      stc_q    <= stc_nx;
      pri_q    <= pri_nx;
      sec_q    <= sec_nx;
      sseq_q   <= sseq_nx;
      cap0_q   <= cap0_nx;
      cap1_q   <= cap1_nx;
      cap2_q   <= cap2_nx;
      cap3_q   <= cap3_nx;
    end
  end

  // mailbox write port
  always_comb begin
    mb_wr    = 1'b0;
    mb_addr  = '0;
    mb_wdata = '0;
    unique case (state_q)
      S_IDLE: begin
        if (rsp_db) begin
          mb_wr    = 1'b1;
          mb_addr  = ADDR_CLEAR;
          mb_wdata = CLEAR_MASK;
        end
      end
      S_WR: begin
        mb_wr   = 1'b1;
        mb_addr = {1'b0, wr_idx_q};
        unique case (wr_idx_q)
          2'd0:    mb_wdata = pack_hdr(hold_q.flags, hseq_q, hold_q.cmd);
          2'd1:    mb_wdata = hold_q.w1;
          2'd2:    mb_wdata = hold_q.w2;
          default: mb_wdata = hold_q.w3;
        endcase
      end
      S_RING: begin
        mb_wr    = 1'b1;
        mb_addr  = ADDR_RING;
        mb_wdata = RING_VAL;
      end
      S_CLR: begin
        mb_wr    = 1'b1;
        mb_addr  = ADDR_CLEAR;
        mb_wdata = CLEAR_MASK;
      end
      default: ;
    endcase
  end

  assign msg_state = ms_q;
  assign st_code   = stc_q;
  assign st_pri    = pri_q;
  assign st_sec    = sec_q;
  assign st_seq    = sseq_q;
  assign rsp_d1    = cap1_q;
  assign rsp_d2    = cap2_q;
  assign rsp_d3    = cap3_q;

  // R3: command words leave in address order, ring follows the last word
  p_wr_order_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mb_wr && mb_addr == 3'd0) |=> (mb_wr && mb_addr == 3'd1));
  p_ring_after_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mb_wr && mb_addr == 3'd3) |=> (mb_wr && mb_addr == ADDR_RING));

  // R2: an illegal class is refused with no command write
  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (q_pop && !head_ok) |=> (st_code == ST_REJECT && !(mb_wr && mb_addr != ADDR_CLEAR)));

  // R4: every accepted command advances the sequence by one
  p_seq_step_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (q_pop && head_ok) |=> (seq_q == SEQ_W'($past(seq_q) + 1'b1)));

  // R6: window expiry without a doorbell ends in timeout
  p_tmo_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == S_WAIT && !rsp_db && tmo_hit) |=> (msg_state == MS_TIMEOUT && st_code == ST_TMO));

  // R7: an accepted response is followed by the doorbell clear
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == S_WAIT && rsp_db) |=> (mb_wr && mb_addr == ADDR_CLEAR));

  // R11: status holds while idle with nothing taken from the queue
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == S_IDLE && !q_pop) |=> $stable(st_code));

endmodule

// File: tb/mbox_cmd_seq_tb.sv
module mbox_cmd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;
  localparam int QD  = 4;
  localparam int SW  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [15:0] req_cmd, req_flags;
  logic [63:0] req_w1, req_w2, req_w3;
  logic        mb_wr;
  logic [2:0]  mb_addr;
  logic [63:0] mb_wdata;
  logic        rsp_db;
  logic [63:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;
  logic [2:0]  msg_state, st_code;
  logic [15:0] st_pri, st_sec, st_seq;
  logic [63:0] rsp_d1, rsp_d2, rsp_d3;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_cmd_seq #(.QDEPTH(QD), .TMO_CYCLES(TMO), .SEQ_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_flags(req_flags),
    .req_w1(req_w1), .req_w2(req_w2), .req_w3(req_w3),
    .mb_wr(mb_wr), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .rsp_db(rsp_db), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1), .rsp_w2(rsp_w2), .rsp_w3(rsp_w3),
    .msg_state(msg_state), .st_code(st_code),
    .st_pri(st_pri), .st_sec(st_sec), .st_seq(st_seq),
    .rsp_d1(rsp_d1), .rsp_d2(rsp_d2), .rsp_d3(rsp_d3)
  );

  // responder model
  logic [63:0] creg [4];
  logic [15:0] cmd_log [64];
  int          dly_cfg, armed_left, n_wr, n_ring, seq_viol, last_addr, cyc, last_cyc, n_log;
  logic [15:0] pri_cfg, sec_cfg;
  logic        corrupt;

  assign rsp_w0 = {pri_cfg, sec_cfg, creg[0][31:0] ^ (corrupt ? 32'h0001_0000 : 32'h0)};
  assign rsp_w1 = ~creg[1];
  assign rsp_w2 = ~creg[2];
  assign rsp_w3 = ~creg[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_db     <= 1'b0;
      armed_left <= 0;
      n_wr       <= 0;
      n_ring     <= 0;
      seq_viol   <= 0;
      last_addr  <= 99;
      cyc        <= 0;
      last_cyc   <= -10;
      n_log      <= 0;
      creg[0] <= '0; creg[1] <= '0; creg[2] <= '0; creg[3] <= '0;
    end else begin
      cyc <= cyc + 1;
      if (armed_left > 0) begin
        if (armed_left == 1) rsp_db <= 1'b1;
        armed_left <= armed_left - 1;
      end
      if (mb_wr) begin
        n_wr <= n_wr + 1;
        if (mb_addr <= 3'd3) creg[mb_addr[1:0]] <= mb_wdata;
        if (int'(mb_addr) >= 1 && int'(mb_addr) <= 4 &&
            (last_addr != int'(mb_addr) - 1 || last_cyc != cyc - 1))
          seq_viol <= seq_viol + 1;
        if (mb_addr == 3'd4 && mb_wdata != 64'h1) seq_viol <= seq_viol + 1;
        last_addr <= int'(mb_addr);
        last_cyc  <= cyc;
        if (mb_addr == 3'd0 && n_log < 64) begin
          cmd_log[n_log] <= mb_wdata[15:0];
          n_log <= n_log + 1;
        end
        if (mb_addr == 3'd4) begin
          n_ring <= n_ring + 1;
          if (creg[0][40] && dly_cfg > 0) armed_left <= dly_cfg;
        end
        if (mb_addr == 3'd5) rsp_db <= rsp_db & mb_wdata[0];
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int exp_seq = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] cmd, input logic [15:0] flags,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_flags = flags;
    req_w1 = a; req_w2 = b; req_w3 = c;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_done();
    bit seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (st_code != 3'd0) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk("completion reached", {63'h0, seen}, 64'h1);
  endtask

  function automatic logic [63:0] hdr(input logic [15:0] f, input int s, input logic [15:0] c);
    return {16'h0, f, 16'(s), c};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] c16;
    logic [63:0] a, b, c;
    int nw, ln;
    logic [7:0] bad_cls [4];
    bad_cls[0] = 8'h00; bad_cls[1] = 8'hD0; bad_cls[2] = 8'hD8; bad_cls[3] = 8'hFF;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_flags = '0;
    req_w1 = '0; req_w2 = '0; req_w3 = '0;
    dly_cfg = 0; pri_cfg = '0; sec_cfg = '0; corrupt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 msg_state", 64'(msg_state), 64'd0);
    chk("R1 st_code", 64'(st_code), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 mb_wr", 64'(mb_wr), 64'd0);

    // R5 no response requested (ack flag only), R3 packing, R4 first seq
    send(16'hD405, 16'h0200, 64'h1111_0000_0000_0001, 64'h2222_0000_0000_0002, 64'h3333_0000_0000_0003);
    wait_done();
    chk("R5 code", 64'(st_code), 64'd1);
    chk("R5 state", 64'(msg_state), 64'd4);
    chk("R3 word0", creg[0], hdr(16'h0200, exp_seq, 16'hD405));
    chk("R3 word1", creg[1], 64'h1111_0000_0000_0001);
    chk("R3 word3", creg[3], 64'h3333_0000_0000_0003);
    chk("R4 first seq", 64'(st_seq), 64'd0);
    exp_seq = (exp_seq + 1) % (1 << SW);

    // R6 R7 R8 R10: sweep response delay across the window
    for (int d = 1; d <= TMO + 1; d++) begin
      dly_cfg = d;
      pri_cfg = (d % 3 == 0) ? 16'h00FE : 16'h0000;
      sec_cfg = 16'(d + 16'h40);
      c16 = {8'hD1 + 8'(d % 7), 8'(d)};
      a = {32'hA5A5_0000, 32'(d)}; b = {32'h5A5A_0000, 32'(d)}; c = {32'hC3C3_0000, 32'(d)};
      send(c16, 16'h0100, a, b, c);
      wait_done();
      chk("R4 seq field", creg[0], hdr(16'h0100, exp_seq, c16));
      if (d <= TMO) begin
        chk("R8 code", 64'(st_code), (pri_cfg == 0) ? 64'd1 : 64'd2);
        chk("R8 pri", 64'(st_pri), 64'(pri_cfg));
        chk("R8 sec", 64'(st_sec), 64'(sec_cfg));
        chk("R6 accepted state", 64'(msg_state), 64'd4);
        chk("R7 word1", rsp_d1, ~a);
        chk("R7 word3", rsp_d3, ~c);
        chk("R7 doorbell cleared", 64'(rsp_db), 64'd0);
        chk("R4 st_seq", 64'(st_seq), 64'(exp_seq));
      end else begin
        chk("R6 timeout code", 64'(st_code), 64'd3);
        chk("R6 timeout state", 64'(msg_state), 64'd5);
        repeat (6) @(negedge clk);
        chk("R10 late doorbell cleared", 64'(rsp_db), 64'd0);
        chk("R10 code kept", 64'(st_code), 64'd3);
        chk("R10 state kept", 64'(msg_state), 64'd5);
      end
      exp_seq = (exp_seq + 1) % (1 << SW);
    end

    // R4 wrap of the sequence counter
    for (int k = 0; k < 10; k++) begin
      c16 = {8'hD7, 8'(k)};
      send(c16, 16'h0000, 64'(k), 64'(k + 1), 64'(k + 2));
      wait_done();
      chk("R4 wrap seq", creg[0], hdr(16'h0000, exp_seq, c16));
      exp_seq = (exp_seq + 1) % (1 << SW);
    end

    // R2 class range
    for (int k = 0; k < 4; k++) begin
      nw = n_wr;
      send({bad_cls[k], 8'h11}, 16'h0100, 64'h0, 64'h0, 64'h0);
      wait_done();
      chk("R2 reject code", 64'(st_code), 64'd5);
      chk("R2 reject state", 64'(msg_state), 64'd6);
      chk("R2 no writes", 64'(n_wr), 64'(nw));
    end
    send(16'hD1AA, 16'h0000, 64'h0, 64'h0, 64'h0);
    wait_done();
    chk("R2 D1 accepted", 64'(st_code), 64'd1);
    chk("R2 seq not consumed", 64'(st_seq), 64'(exp_seq));
    exp_seq = (exp_seq + 1) % (1 << SW);

    // R9 header mismatch
    dly_cfg = 2; pri_cfg = 16'h0; corrupt = 1'b1;
    send(16'hD302, 16'h0100, 64'h7, 64'h8, 64'h9);
    wait_done();
    chk("R9 code", 64'(st_code), 64'd4);
    chk("R9 state", 64'(msg_state), 64'd6);
    corrupt = 1'b0;
    exp_seq = (exp_seq + 1) % (1 << SW);

    // R11 hold until next acceptance
    repeat (10) @(negedge clk);
    chk("R11 held", 64'(st_code), 64'd4);
    dly_cfg = TMO;
    send(16'hD601, 16'h0100, 64'h1, 64'h2, 64'h3);
    chk("R11 cleared on accept", 64'(st_code), 64'd0);
    wait_done();
    chk("R11 next result", 64'(st_code), 64'd1);
    exp_seq = (exp_seq + 1) % (1 << SW);

    // R12 queue order and full flag
    ln = n_log;
    send(16'hD1A0, 16'h0100, 64'h0, 64'h0, 64'h0);
    for (int k = 1; k <= 4; k++) begin
      req_valid = 1'b1; req_cmd = {8'hD2, 8'hA0 + 8'(k)}; req_flags = 16'h0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R12 ready low when full", 64'(req_ready), 64'd0);
    repeat (120) @(negedge clk);
    chk("R12 ready restored", 64'(req_ready), 64'd1);
    chk("R12 order A", 64'(cmd_log[ln]), 64'h00D1A0);
    for (int k = 1; k <= 4; k++)
      chk("R12 order", 64'(cmd_log[ln + k]), 64'({8'hD2, 8'hA0 + 8'(k)}));
    chk("R3 write sequencing", 64'(seq_viol), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule